// File: doc/BRIEF.md
# Alternating Frame Buffer Fetch Sequencer

This block produces the memory read addresses that keep a display refreshed. Two frame buffer regions are programmed, each as a word-aligned base address and an inclusive ceiling address. When alternation is enabled, successive frames are read from region 0, then region 1, then region 0 again, and so on. When it is disabled, every frame comes from region 0. Reads go out as bursts on a request/grant port. A request carries a start address and a length in words. The last burst of a region is cut short so that the ceiling is never passed.

A short colour table region can be fetched before any pixel data. A load-mode field picks one of three behaviours: table then frames, table only, or frames only. Each finished region raises a one-cycle event. There is one event per frame buffer and one for the colour table. Software uses the frame events as the moment to reprogram the buffer that has just been released. Configuration arrives through a small write port, and the `run` input starts and stops fetching.

Top module: `fbdma_seq`

## Requirements
- R1: The burst code in control bits 6:4 selects 1, 2, 4, 8 or 16 words for codes 0, 1, 2, 3 and 4. A write carrying code 5, 6 or 7 leaves the previous burst size in force. The size in force is taken at the start of each region.
- R2: The load mode in control bits 21:20 selects the behaviour: 0 is table then frames, 1 is table only, 2 is frames only. A write of 3 leaves the previous mode in force.
- R3: A region is read from base to ceiling inclusive in ascending, back-to-back bursts. Every burst has the selected length except the last, which is cut to the words that remain. No requested word lies beyond the ceiling.
- R4: Control bit 0 set makes frames alternate between buffer 0 and buffer 1, starting with buffer 0. With the bit clear, every frame is read from buffer 0.
- R5: In the cycle after the final grant of a frame, `eof0` pulses for one cycle if the frame came from buffer 0, or `eof1` if it came from buffer 1. At most one of `eof0`, `eof1` and `pal_done` is high in any cycle.
- R6: Base and ceiling values written while a frame is being fetched leave that frame unchanged. They are used the next time that buffer starts a frame.
- R7: The table region starts at the table base. Control bit 8 selects its size: 32 bytes when clear, 512 bytes when set. In the cycle after its final grant, `pal_done` pulses. In table-only mode no further request is made until `run` falls.
- R8: In table-then-frames mode, the first frame after the table is read from buffer 0.
- R9: Once raised, a request keeps its address and length unchanged until the cycle in which it is granted.
- R10: After reset there is no request and no event. When `run` falls, the request already raised is completed and no new one follows.
- R11: Write select codes: 0 control, 1 base 0, 2 ceiling 0, 3 base 1, 4 ceiling 1, 5 table base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Fetching enabled while high |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 3 | Configuration register select (R11) |
| wr_data | input | 32 | Configuration write data |
| rd_req | output | 1 | Burst request |
| rd_addr | output | AW | Byte address of the first word of the burst |
| rd_len | output | 5 | Burst length in words |
| rd_gnt | input | 1 | Grant; a burst is accepted on a clock edge where both request and grant are high |
| eof0 | output | 1 | Frame from buffer 0 finished |
| eof1 | output | 1 | Frame from buffer 1 finished |
| pal_done | output | 1 | Table region finished |

## Verification
The assertions assume three things about the programmed regions:
- every base is word aligned;
- every ceiling is one byte below a word boundary;
- no ceiling lies below its base.

Under those conditions, the remaining-word arithmetic and the overrun bound hold. The stimulus only writes addresses built as a base plus a whole number of words, minus one byte. Grant delays vary from zero to two cycles, so the hold property is exercised while a request is waiting. Stops and mid-frame writes are issued only at cycle boundaries, away from the clock edge.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

    localparam int LEN_W          = 5;
    localparam int BURST_CODE_MAX = 4;

    localparam int CTRL_ALT_BIT   = 0;
    localparam int CTRL_BURST_LSB = 4;
    localparam int CTRL_WIDE_BIT  = 8;
    localparam int CTRL_MODE_LSB  = 20;

    typedef enum logic [1:0] {
        MODE_TBL_FRM  = 2'd0,
        MODE_TBL_ONLY = 2'd1,
        MODE_FRM_ONLY = 2'd2
    } ldmode_e;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_BASE0 = 3'd1,
        SEL_CEIL0 = 3'd2,
        SEL_BASE1 = 3'd3,
        SEL_CEIL1 = 3'd4,
        SEL_TBASE = 3'd5
    } regsel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_HALT  = 2'd3
    } state_e;

endpackage

// File: rtl/fbdma_regs.sv
module fbdma_regs
    import fbdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          alt_en,
    output logic [2:0]    burst_code,
    output logic          tbl_wide,
    output logic [1:0]    load_mode,
    output logic [AW-1:0] base0,
    output logic [AW-1:0] ceil0,
    output logic [AW-1:0] base1,
    output logic [AW-1:0] ceil1,
    output logic [AW-1:0] tbl_base
);

    typedef struct packed {
        logic          alt;
        logic [2:0]    bcode;
        logic          wide;
        logic [1:0]    mode;
        logic [AW-1:0] b0;
        logic [AW-1:0] c0;
        logic [AW-1:0] b1;
        logic [AW-1:0] c1;
        logic [AW-1:0] tb;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [2:0] new_code;
    logic [1:0] new_mode;

    assign new_code = wr_data[CTRL_BURST_LSB +: 3];
    assign new_mode = wr_data[CTRL_MODE_LSB +: 2];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (regsel_e'(wr_sel))
                SEL_CTRL: begin
                    regs_d.alt  = wr_data[CTRL_ALT_BIT];
                    regs_d.wide = wr_data[CTRL_WIDE_BIT];
                    // illegal burst codes are dropped, the old size stays
                    if (int'(new_code) <= BURST_CODE_MAX)
                        regs_d.bcode = new_code;
                    // the reserved mode value is dropped as well
                    if (new_mode != 2'd3)
                        regs_d.mode = new_mode;
                end
                SEL_BASE0: regs_d.b0 = wr_data[AW-1:0];
                SEL_CEIL0: regs_d.c0 = wr_data[AW-1:0];
                SEL_BASE1: regs_d.b1 = wr_data[AW-1:0];
                SEL_CEIL1: regs_d.c1 = wr_data[AW-1:0];
                SEL_TBASE: regs_d.tb = wr_data[AW-1:0];
                default:   regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign alt_en     = regs_q.alt;
    assign burst_code = regs_q.bcode;
    assign tbl_wide   = regs_q.wide;
    assign load_mode  = regs_q.mode;
    assign base0      = regs_q.b0;
    assign ceil0      = regs_q.c0;
    assign base1      = regs_q.b1;
    assign ceil1      = regs_q.c1;
    assign tbl_base   = regs_q.tb;

    AST_BURST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 3'd0 && int'(wr_data[CTRL_BURST_LSB +: 3]) > BURST_CODE_MAX
        |=> $stable(burst_code)) else $error("illegal burst code accepted"); // R1
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 3'd0 && wr_data[CTRL_MODE_LSB +: 2] == 2'd3
        |=> $stable(load_mode)) else $error("reserved mode accepted"); // R2

endmodule

// File: rtl/fbdma_len.sv
module fbdma_len
    import fbdma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int WB_LOG = 2
) (
    input  logic [AW-1:0]    addr,
    input  logic [AW-1:0]    ceil,
    input  logic [2:0]       code,
    output logic [LEN_W-1:0] len,
    output logic             last
);

    logic [AW-1:0]    words_left;
    logic [LEN_W-1:0] full_len;

    assign words_left = ((ceil - addr) >> WB_LOG) + AW'(1);
    assign full_len   = LEN_W'(1) << code;

    always_comb begin
        if (words_left <= AW'(full_len)) begin
            len  = words_left[LEN_W-1:0];
            last = 1'b1;
        end else begin
            len  = full_len;
            last = 1'b0;
        end
    end

endmodule

// File: rtl/fbdma_seq.sv
module fbdma_seq
    import fbdma_pkg::*;
#(
    parameter int AW              = 32,
    parameter int WB_LOG          = 2,
    parameter int TBL_SMALL_BYTES = 32,
    parameter int TBL_LARGE_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [31:0]      wr_data,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    output logic [LEN_W-1:0] rd_len,
    input  logic             rd_gnt,
    output logic             eof0,
    output logic             eof1,
    output logic             pal_done
);

    localparam logic [AW-1:0] TBL_SMALL_SPAN = AW'(TBL_SMALL_BYTES - 1);
    localparam logic [AW-1:0] TBL_LARGE_SPAN = AW'(TBL_LARGE_BYTES - 1);

    logic          alt_en, tbl_wide;
    logic [2:0]    burst_code;
    logic [1:0]    load_mode;
    logic [AW-1:0] base0, ceil0, base1, ceil1, tbl_base;

    fbdma_regs #(.AW(AW), .DW(32)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .alt_en     (alt_en),
        .burst_code (burst_code),
        .tbl_wide   (tbl_wide),
        .load_mode  (load_mode),
        .base0      (base0),
        .ceil0      (ceil0),
        .base1      (base1),
        .ceil1      (ceil1),
        .tbl_base   (tbl_base)
    );

    typedef struct packed {
        state_e        st;
        logic          tbl;
        logic          buf_sel;
        logic [1:0]    mode;
        logic [2:0]    bcode;
        logic [AW-1:0] addr;
        logic [AW-1:0] ceil;
        logic          ev0;
        logic          ev1;
        logic          evt;
    } seq_t;

    seq_t s_d, s_q;

    logic [LEN_W-1:0] cur_len;
    logic             cur_last;

    fbdma_len #(.AW(AW), .WB_LOG(WB_LOG)) u_len (
        .addr (s_q.addr),
        .ceil (s_q.ceil),
        .code (s_q.bcode),
        .len  (cur_len),
        .last (cur_last)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ev0 = 1'b0;
        s_d.ev1 = 1'b0;
        s_d.evt = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (run) begin
                    s_d.buf_sel = 1'b0;
                    s_d.mode    = load_mode;
                    if (load_mode != MODE_FRM_ONLY) begin
                        s_d.tbl   = 1'b1;
                        s_d.bcode = burst_code;
                        s_d.addr  = tbl_base;
                        s_d.ceil  = tbl_base + (tbl_wide ? TBL_LARGE_SPAN : TBL_SMALL_SPAN);
                        s_d.st    = ST_ISSUE;
                    end else begin
                        s_d.st = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                if (!run) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.tbl   = 1'b0;
                    s_d.bcode = burst_code;
                    s_d.addr  = s_q.buf_sel ? base1 : base0;
                    s_d.ceil  = s_q.buf_sel ? ceil1 : ceil0;
                    s_d.st    = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (rd_gnt) begin
                    if (!cur_last) begin
                        s_d.addr = s_q.addr + (AW'(cur_len) << WB_LOG);
                    end else if (s_q.tbl) begin
                        s_d.evt     = 1'b1;
                        s_d.buf_sel = 1'b0;
                        s_d.st      = (s_q.mode == MODE_TBL_ONLY) ? ST_HALT : ST_LOAD;
                    end else begin
                        s_d.ev0     = ~s_q.buf_sel;
                        s_d.ev1     = s_q.buf_sel;
                        s_d.buf_sel = alt_en ? ~s_q.buf_sel : 1'b0;
                        s_d.st      = ST_LOAD;
                    end
                    if (!run) s_d.st = ST_IDLE;
                end
            end
            ST_HALT: begin
                if (!run) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_req   = (s_q.st == ST_ISSUE);
    assign rd_addr  = s_q.addr;
    assign rd_len   = cur_len;
    assign eof0     = s_q.ev0;
    assign eof1     = s_q.ev1;
    assign pal_done = s_q.evt;

    logic [AW:0] burst_end;
    assign burst_end = {1'b0, rd_addr} + ((AW+1)'(rd_len) << WB_LOG) - (AW+1)'(1);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_gnt |=> rd_req && $stable(rd_addr) && $stable(rd_len))
        else $error("request changed before grant"); // R9
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_len != '0 && rd_len <= (LEN_W'(1) << s_q.bcode))
        else $error("burst length out of range"); // R1
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> burst_end <= {1'b0, s_q.ceil})
        else $error("burst passes ceiling"); // R3
    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eof0, eof1, pal_done}))
        else $error("two events at once"); // R5
    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (eof0 || eof1) |=> !eof0 && !eof1)
        else $error("frame event longer than one cycle"); // R5
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !rd_req |=> !rd_req)
        else $error("request after stop"); // R10

endmodule

// File: tb/sim_fbdma_seq.sv
module sim_fbdma_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [31:0] wr_data = 32'd0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [4:0]  rd_len;
    logic        rd_gnt = 1'b0;
    logic        eof0, eof1, pal_done;

    int n_chk = 0;
    int n_err = 0;
    int gdly  = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    fbdma_seq u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_gnt(rd_gnt), .eof0(eof0), .eof1(eof1), .pal_done(pal_done)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog expired (all requirements) actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // R11 select codes: 0 control, 1 base0, 2 ceil0, 3 base1, 4 ceil1, 5 table base
    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // control: bit0 alternate (R4), bits6:4 burst code (R1), bit8 wide table (R7), bits21:20 mode (R2)
    function automatic logic [31:0] ctrl(input int mode, input int code, input bit wide, input bit alt);
        return (32'(mode) << 20) | (32'(code) << 4) | (32'(wide) << 8) | 32'(alt);
    endfunction

    task automatic wait_req(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (rd_req) begin ok = 1'b1; return; end
            @(negedge clk);
        end
    endtask

    // ev: 0 -> eof0, 1 -> eof1, 2 -> pal_done
    task automatic do_region(input logic [31:0] base, input logic [31:0] ceil, input int blen,
                             input int ev, input string tag,
                             input bit mw, input logic [31:0] mb, input logic [31:0] mc);
        logic [31:0] a;
        int rem, el;
        bit ok, first;
        a = base;
        first = 1'b1;
        while (a <= ceil) begin
            rem = int'((ceil - a + 32'd1) >> 2);
            el  = (rem < blen) ? rem : blen;
            wait_req(ok);
            chk(ok, {tag, " R3 request expected"}, 64'(rd_req), 64'd1);
            if (!ok) return;
            chk(rd_addr == a && int'(rd_len) == el, {tag, " R1 R3 burst addr/len"},
                {rd_addr, 27'd0, rd_len}, {a, 27'd0, 5'(el)});
            for (int d = 0; d < gdly % 3; d++) begin
                @(negedge clk);
                chk(rd_req && rd_addr == a && int'(rd_len) == el, {tag, " R9 held until grant"},
                    {rd_addr, 27'd0, rd_len}, {a, 27'd0, 5'(el)});
            end
            gdly++;
            rd_gnt = 1'b1;
            @(negedge clk);
            rd_gnt = 1'b0;
            a = a + 32'(el * 4);
            if (a > ceil) begin
                chk({pal_done, eof1, eof0} == (3'b001 << ev), {tag, " R5 R7 completion event"},
                    64'({pal_done, eof1, eof0}), 64'(3'b001 << ev));
            end else if (mw && first) begin
                wr(3'd1, mb);
                wr(3'd2, mc);
            end
            first = 1'b0;
        end
    endtask

    task automatic stop_and_quiet(input string tag);
        run = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!rd_req, {tag, " R10 no request after stop"}, 64'(rd_req), 64'd0);
        end
    endtask

    initial begin
        bit ok;
        logic [31:0] b, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_req && !eof0 && !eof1 && !pal_done, "R10 reset state",
            64'({rd_req, eof0, eof1, pal_done}), 64'd0);

        // R1 R3: sweep every burst code against region sizes of 1..20 words
        for (int code = 0; code < 5; code++) begin
            for (int w = 1; w <= 20; w++) begin
                b = 32'h1000 + 32'(code) * 32'h400;
                c = b + 32'(w * 4) - 32'd1;
                wr(3'd1, b);
                wr(3'd2, c);
                wr(3'd0, ctrl(2, code, 1'b0, 1'b0));
                @(negedge clk);
                run = 1'b1;
                do_region(b, c, 1 << code, 0, "sweep", 1'b0, 0, 0);
                stop_and_quiet("sweep");
            end
        end

        // R1: illegal code 7 keeps 2-word bursts; R2: reserved mode keeps frames-only
        wr(3'd0, ctrl(2, 1, 1'b0, 1'b0));
        wr(3'd0, ctrl(2, 7, 1'b0, 1'b0));
        wr(3'd0, ctrl(3, 1, 1'b0, 1'b0));
        wr(3'd5, 32'h8000);
        wr(3'd1, 32'h2000);
        wr(3'd2, 32'h201B);
        @(negedge clk);
        run = 1'b1;
        do_region(32'h2000, 32'h201B, 2, 0, "R1 R2 rejected fields", 1'b0, 0, 0);
        stop_and_quiet("R2");

        // R4 R5 R6: alternation, with buffer 0 rewritten mid-frame
        wr(3'd1, 32'h2000); wr(3'd2, 32'h203F);
        wr(3'd3, 32'h3000); wr(3'd4, 32'h301F);
        wr(3'd0, ctrl(2, 2, 1'b0, 1'b1));
        @(negedge clk);
        run = 1'b1;
        do_region(32'h2000, 32'h203F, 4, 0, "R4 R6 frame0 old", 1'b1, 32'h5000, 32'h500F);
        do_region(32'h3000, 32'h301F, 4, 1, "R4 frame1", 1'b0, 0, 0);
        do_region(32'h5000, 32'h500F, 4, 0, "R6 frame0 new", 1'b0, 0, 0);
        do_region(32'h3000, 32'h301F, 4, 1, "R4 frame1 again", 1'b0, 0, 0);
        stop_and_quiet("R4");

        // R4: alternation off, every frame from buffer 0
        wr(3'd0, ctrl(2, 3, 1'b0, 1'b0));
        @(negedge clk);
        run = 1'b1;
        do_region(32'h5000, 32'h500F, 8, 0, "R4 single a", 1'b0, 0, 0);
        do_region(32'h5000, 32'h500F, 8, 0, "R4 single b", 1'b0, 0, 0);
        stop_and_quiet("R4 single");

        // R7: table-only, small table, then halt
        wr(3'd0, ctrl(1, 3, 1'b0, 1'b0));
        @(negedge clk);
        run = 1'b1;
        do_region(32'h8000, 32'h801F, 8, 2, "R7 small table", 1'b0, 0, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!rd_req && !eof0 && !eof1, "R7 halted after table", 64'(rd_req), 64'd0);
        end
        stop_and_quiet("R7");

        // R7: wide table
        wr(3'd0, ctrl(1, 4, 1'b1, 1'b0));
        @(negedge clk);
        run = 1'b1;
        do_region(32'h8000, 32'h81FF, 16, 2, "R7 wide table", 1'b0, 0, 0);
        stop_and_quiet("R7 wide");

        // R8: table then frames, frames start on buffer 0 and alternate
        wr(3'd0, ctrl(0, 2, 1'b0, 1'b1));
        @(negedge clk);
        run = 1'b1;
        do_region(32'h8000, 32'h801F, 4, 2, "R8 table", 1'b0, 0, 0);
        do_region(32'h5000, 32'h500F, 4, 0, "R8 first frame", 1'b0, 0, 0);
        do_region(32'h3000, 32'h301F, 4, 1, "R8 second frame", 1'b0, 0, 0);
        stop_and_quiet("R8");

        // R10: stop while a request waits for grant
        wr(3'd1, 32'h6000); wr(3'd2, 32'h600F);
        wr(3'd0, ctrl(2, 0, 1'b0, 1'b0));
        @(negedge clk);
        run = 1'b1;
        wait_req(ok);
        chk(ok && rd_addr == 32'h6000, "R10 first request", 64'(rd_addr), 64'h6000);
        run = 1'b0;
        @(negedge clk);
        chk(rd_req && rd_addr == 32'h6000, "R10 pending request kept", 64'(rd_req), 64'd1);
        rd_gnt = 1'b1;
        @(negedge clk);
        rd_gnt = 1'b0;
        chk(!rd_req && !eof0, "R10 stop after granted burst", 64'({rd_req, eof0}), 64'd0);
        stop_and_quiet("R10");

        summary();
        $finish;
    end

endmodule